// File: doc/BRIEF.md
# Synchronous Serial Master Shifter

This block is the master-side shift engine of a synchronous serial port. It takes words from a transmit queue through a valid/ready pair and shifts each one out most-significant bit first on the data output. In the same word it collects the same number of bits from the data input, and it offers the assembled word on a receive valid/ready pair. It drives the serial clock and an active-low frame select, and it reports activity on a busy flag.

The serial clock comes from two counters in cascade. An even prescale value sets the first stage, and an 8-bit rate factor sets the second, so one bit lasts `prescale * (1 + rate_fac)` input clocks. A two-bit mode code selects the clock idle level and the sampling edge. The word width can be anything from 4 to 16 bits. Clock polarity, phase, width and divider settings are captured when each word is loaded. While `busy` is high, the settings must be held steady.

A word is taken from the transmit side only when the receive holding register is empty, so received data is never overwritten. The frame select stays low across consecutive words for as long as transmit data keeps arriving. Between two words there is a short gap in which the clock stays at its idle level. Dropping `enable` stops everything at once.

Top module: `ssm_engine`

## Requirements
- R1: One serial clock half period lasts `max(1, prescale>>1) * (rate_fac + 1)` input clocks. Bit 0 of `prescale` is ignored, and values below 2 act as 2. A full bit lasts two half periods.
- R2: Bit 1 of `mode` is the clock polarity and bit 0 is the phase. Mode codes map as 0 = {pol 0, pha 0}, 1 = {0,1}, 2 = {1,0}, 3 = {1,1}. When idle, `sclk` rests at the polarity level.
- R3: Bits leave MSB first. With phase 0, the first bit is on `mosi` from the load, `miso` is sampled on each leading clock edge, and `mosi` changes on each trailing edge. With phase 1, `mosi` changes on each leading edge and `miso` is sampled on each trailing edge.
- R4: The word width is `width_m1 + 1`, and codes below 3 act as 4 bits. Transmit bits above the width are ignored. Bits of `rx_data` above the width read as zero.
- R5: `rx_valid` rises one clock after the final edge of a word. After that, `rx_valid` and `rx_data` hold steady until they are taken with `rx_ready`.
- R6: `fss_n` falls on the clock that loads a word. It stays low through the gap between words while `tx_valid` is high, and it rises once the transmit side runs empty or the block is idle. `mosi` is 0 whenever no word is shifting.
- R7: `tx_ready` is high only when `enable` is set, no word is shifting and the receive holding register is empty.
- R8: `busy` is high while a word is shifting or a frame is open, and while `enable` is set with `tx_valid` high. It is low only after the last bit has left.
- R9: When `enable` is low, the block returns to idle on the next clock. The partial word is dropped, `fss_n` goes high, `sclk` returns to the polarity level and no word is taken.
- R10: After reset, `fss_n` is 1, `mosi` is 0, `rx_valid` is 0 and `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Port enable |
| mode | input | 2 | {polarity, phase} code |
| width_m1 | input | 4 | Word width minus one |
| prescale | input | 8 | Even prescale value, 2 to 254 |
| rate_fac | input | 8 | Serial clock rate factor, 0 to 255 |
| tx_valid | input | 1 | Transmit word available |
| tx_data | input | 16 | Transmit word |
| tx_ready | output | 1 | Transmit word taken this clock |
| rx_valid | output | 1 | Received word available |
| rx_data | output | 16 | Received word, zero above width |
| rx_ready | input | 1 | Received word taken |
| sclk | output | 1 | Serial clock |
| fss_n | output | 1 | Active-low frame select |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| busy | output | 1 | Activity status |

## Verification
A wrong divider count or half-period flag shows up within one half period: `sclk` toggles a clock early or late compared with the reference. A bit counter or width decode that is off by one moves the `mosi` bit stream one edge early or late and shifts the recovered `rx_data` by one bit. This is visible at the latest when `rx_valid` rises at the end of that word. A faulty receive-room check or frame-state error shows up as `tx_ready`, `fss_n` or `busy` differing from the reference model in the very cycle the state diverges. The bench holds `rx_ready` low and toggles it so that the stalled-gap state is reached.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

    localparam int SSM_MAX_W  = 16;
    localparam int SSM_IDX_W  = $clog2(SSM_MAX_W);
    localparam int SSM_PRE_W  = 8;
    localparam int SSM_HALF_W = SSM_PRE_W - 1;
    localparam int SSM_RATE_W = 8;
    localparam int SSM_MIN_W  = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_GAP   = 2'd2
    } ssm_state_e;

    typedef struct packed {
        logic                  pol;
        logic                  pha;
        logic [SSM_IDX_W-1:0]  wm1;
        logic [SSM_HALF_W-1:0] half_pre;
        logic [SSM_RATE_W-1:0] rate;
    } ssm_cfg_t;

    // Width code clamped to the narrowest legal word.
    function automatic logic [SSM_IDX_W-1:0] eff_wm1(input logic [SSM_IDX_W-1:0] w);
        return (w < SSM_IDX_W'(SSM_MIN_W - 1)) ? SSM_IDX_W'(SSM_MIN_W - 1) : w;
    endfunction

    // Ones in the low (wm1 + 1) bit positions.
    function automatic logic [SSM_MAX_W-1:0] width_mask(input logic [SSM_IDX_W-1:0] wm1);
        logic [SSM_MAX_W:0] m;
        m = ({{SSM_MAX_W{1'b0}}, 1'b1} << ({1'b0, wm1} + 1'b1)) - 1'b1;
        return m[SSM_MAX_W-1:0];
    endfunction

    // First divider stage counts half the prescale; low bit dropped, minimum one.
    function automatic logic [SSM_HALF_W-1:0] half_pre_of(input logic [SSM_PRE_W-1:0] p);
        return (p[SSM_PRE_W-1:1] == '0) ? SSM_HALF_W'(1) : p[SSM_PRE_W-1:1];
    endfunction

endpackage

// File: rtl/ssm_rate_div.sv
module ssm_rate_div #(
    parameter int HALF_W = 7,
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [HALF_W-1:0] half_pre,
    input  logic [RATE_W-1:0] rate_fac,
    output logic              tick
);
    logic [HALF_W-1:0] pre_q;
    logic [RATE_W-1:0] rate_q;
    logic              pre_wrap;
    logic              rate_wrap;

    assign pre_wrap  = (pre_q == half_pre - HALF_W'(1));
    assign rate_wrap = (rate_q == rate_fac);
    assign tick      = run && pre_wrap && rate_wrap;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pre_q  <= '0;
            rate_q <= '0;
        end else if (pre_wrap) begin
            pre_q  <= '0;
            rate_q <= rate_wrap ? '0 : rate_q + RATE_W'(1);
        end else begin
            pre_q  <= pre_q + HALF_W'(1);
        end
    end

    // R1: first-stage count never leaves its programmed range while running
    assert_pre_range_R1: assert property (@(posedge clk) disable iff (rst)
        run |-> (pre_q < half_pre));

    // R1: second-stage count never passes the rate factor while running
    assert_rate_range_R1: assert property (@(posedge clk) disable iff (rst)
        run |-> (rate_q <= rate_fac));

endmodule

// File: rtl/ssm_shift_core.sv
module ssm_shift_core
    import ssm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  enable,
    input  logic [1:0]            mode,
    input  logic [SSM_IDX_W-1:0]  width_m1,
    input  logic [SSM_PRE_W-1:0]  prescale,
    input  logic [SSM_RATE_W-1:0] rate_fac,
    input  logic                  tx_valid,
    input  logic [SSM_MAX_W-1:0]  tx_data,
    output logic                  tx_ready,
    output logic                  rx_valid,
    output logic [SSM_MAX_W-1:0]  rx_data,
    input  logic                  rx_ready,
    output logic                  sclk,
    output logic                  fss_n,
    output logic                  mosi,
    input  logic                  miso,
    output logic                  busy,
    input  logic                  tick,
    output logic                  run,
    output logic [SSM_HALF_W-1:0] div_half,
    output logic [SSM_RATE_W-1:0] div_rate
);
    ssm_state_e            state_q;
    ssm_cfg_t              cfg_q;
    ssm_cfg_t              cfg_new;
    logic [SSM_MAX_W-1:0]  txw_q;
    logic [SSM_MAX_W-1:0]  rxw_q;
    logic [SSM_MAX_W-1:0]  rx_next;
    logic [SSM_IDX_W-1:0]  bit_q;
    logic                  second_q;
    logic                  sclk_q;
    logic                  mosi_q;
    logic                  fss_q;
    logic                  rxv_q;
    logic [SSM_MAX_W-1:0]  rxd_q;
    logic                  load;

    always_comb begin
        cfg_new.pol      = mode[1];
        cfg_new.pha      = mode[0];
        cfg_new.wm1      = eff_wm1(width_m1);
        cfg_new.half_pre = half_pre_of(prescale);
        cfg_new.rate     = rate_fac;
    end

    assign tx_ready = enable && (state_q != ST_SHIFT) && !rxv_q;
    assign load     = tx_ready && tx_valid;
    assign rx_next  = {rxw_q[SSM_MAX_W-2:0], miso};

    assign run      = (state_q == ST_SHIFT);
    assign div_half = cfg_q.half_pre;
    assign div_rate = cfg_q.rate;

    assign sclk     = (state_q == ST_IDLE) ? mode[1] : sclk_q;
    assign fss_n    = fss_q;
    assign mosi     = mosi_q;
    assign rx_valid = rxv_q;
    assign rx_data  = rxd_q;
    assign busy     = (state_q != ST_IDLE) || (enable && tx_valid);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            cfg_q    <= '0;
            txw_q    <= '0;
            rxw_q    <= '0;
            bit_q    <= '0;
            second_q <= 1'b0;
            sclk_q   <= 1'b0;
            mosi_q   <= 1'b0;
            fss_q    <= 1'b1;
            rxv_q    <= 1'b0;
            rxd_q    <= '0;
        end else begin
            if (rxv_q && rx_ready) rxv_q <= 1'b0;

            if (!enable) begin
                state_q <= ST_IDLE;
                fss_q   <= 1'b1;
                mosi_q  <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_IDLE, ST_GAP: begin
                        if (load) begin
                            state_q  <= ST_SHIFT;
                            cfg_q    <= cfg_new;
                            txw_q    <= tx_data & width_mask(cfg_new.wm1);
                            rxw_q    <= '0;
                            bit_q    <= cfg_new.wm1;
                            second_q <= 1'b0;
                            sclk_q   <= cfg_new.pol;
                            mosi_q   <= cfg_new.pha ? 1'b0 : tx_data[cfg_new.wm1];
                            fss_q    <= 1'b0;
                        end else if (state_q == ST_GAP && !tx_valid) begin
                            state_q <= ST_IDLE;
                            fss_q   <= 1'b1;
                        end
                    end
                    ST_SHIFT: begin
                        if (tick) begin
                            sclk_q   <= ~sclk_q;
                            second_q <= ~second_q;
                            if (!second_q) begin
                                if (!cfg_q.pha) rxw_q  <= rx_next;
                                else            mosi_q <= txw_q[bit_q];
                            end else begin
                                if (cfg_q.pha) rxw_q <= rx_next;
                                if (bit_q == '0) begin
                                    state_q <= ST_GAP;
                                    rxv_q   <= 1'b1;
                                    rxd_q   <= cfg_q.pha ? rx_next : rxw_q;
                                    mosi_q  <= 1'b0;
                                end else begin
                                    bit_q <= bit_q - SSM_IDX_W'(1);
                                    if (!cfg_q.pha) mosi_q <= txw_q[bit_q - SSM_IDX_W'(1)];
                                end
                            end
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    // R1: the serial clock moves only on a divider tick
    assert_sclk_steady_R1: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SHIFT) && !tick && enable |=> $stable(sclk_q));

    // R4: bits above the configured width are zero in a presented word
    assert_rx_upper_zero_R4: assert property (@(posedge clk) disable iff (rst)
        rxv_q |-> ((rxd_q & ~width_mask(cfg_q.wm1)) == '0));

    // R5: an untaken received word is held unchanged
    assert_rx_hold_R5: assert property (@(posedge clk) disable iff (rst)
        rxv_q && !rx_ready |=> rxv_q && $stable(rxd_q));

    // R6: no frame is open while idle
    assert_idle_frame_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |-> fss_q);

    // R7: an accepted transmit word opens shifting with the frame low
    assert_load_starts_R7: assert property (@(posedge clk) disable iff (rst)
        tx_valid && tx_ready |=> (state_q == ST_SHIFT) && !fss_q);

    // R9: dropping enable closes the frame on the next clock
    assert_disable_stops_R9: assert property (@(posedge clk) disable iff (rst)
        !enable |=> fss_q && (state_q == ST_IDLE));

endmodule

// File: rtl/ssm_engine.sv
module ssm_engine
    import ssm_pkg::*;
#(
    parameter int DATA_W = SSM_MAX_W,
    parameter int PRE_W  = SSM_PRE_W,
    parameter int RATE_W = SSM_RATE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [1:0]        mode,
    input  logic [3:0]        width_m1,
    input  logic [PRE_W-1:0]  prescale,
    input  logic [RATE_W-1:0] rate_fac,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_ready,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    input  logic              rx_ready,
    output logic              sclk,
    output logic              fss_n,
    output logic              mosi,
    input  logic              miso,
    output logic              busy
);
    localparam int HALF_W = PRE_W - 1;

    logic              tick;
    logic              run;
    logic [HALF_W-1:0] div_half;
    logic [RATE_W-1:0] div_rate;

    ssm_shift_core u_core (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .mode     (mode),
        .width_m1 (width_m1),
        .prescale (prescale),
        .rate_fac (rate_fac),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_ready (tx_ready),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .rx_ready (rx_ready),
        .sclk     (sclk),
        .fss_n    (fss_n),
        .mosi     (mosi),
        .miso     (miso),
        .busy     (busy),
        .tick     (tick),
        .run      (run),
        .div_half (div_half),
        .div_rate (div_rate)
    );

    ssm_rate_div #(
        .HALF_W (HALF_W),
        .RATE_W (RATE_W)
    ) u_div (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .half_pre (div_half),
        .rate_fac (div_rate),
        .tick     (tick)
    );

endmodule

// File: tb/ssm_engine_tb_top.sv
module ssm_engine_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [3:0]  width_m1 = 4'd7;
    logic [7:0]  prescale = 8'd2;
    logic [7:0]  rate_fac = 8'd0;
    logic        tx_valid = 1'b0;
    logic [15:0] tx_data = 16'd0;
    logic        rx_ready = 1'b1;
    logic        miso = 1'b0;
    logic        tx_ready, rx_valid, sclk, fss_n, mosi, busy;
    logic [15:0] rx_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    ssm_engine dut_i (
        .clk(clk), .rst(rst), .enable(enable), .mode(mode), .width_m1(width_m1),
        .prescale(prescale), .rate_fac(rate_fac), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .sclk(sclk), .fss_n(fss_n), .mosi(mosi), .miso(miso), .busy(busy)
    );

    // scenario requests, applied at the next falling edge
    logic        en_r = 1'b0;
    logic [1:0]  mode_r = 2'd0;
    logic [3:0]  wm1_r = 4'd7;
    logic [7:0]  pre_r = 8'd2;
    logic [7:0]  rate_r = 8'd0;
    int          rdy_mode = 0;
    logic [15:0] txq[$];

    // reference model: 0 idle, 1 shifting, 2 gap
    int m_st = 0, m_sclk = 0, m_fss = 1, m_mosi = 0, m_rxv = 0, m_rxd = 0;
    int m_pol = 0, m_pha = 0, m_w = 8, m_h = 1, m_cyc = 0, m_e = 0, m_acc = 0, m_word = 0;
    bit model_on = 1'b0;

    logic [15:0] lfsr = 16'hACE1;
    int n_tests = 0, n_fail = 0, cyc_cnt = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary_and_end();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    always @(negedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > WATCHDOG) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc_cnt, WATCHDOG);
            summary_and_end();
        end
        if (model_on) begin
            int e_sclk, e_txr, e_busy;
            e_sclk = (m_st == 0) ? int'(mode[1]) : m_sclk;
            e_txr  = (enable && m_st != 1 && m_rxv == 0) ? 1 : 0;
            e_busy = (m_st != 0 || (enable && tx_valid)) ? 1 : 0;
            chk(int'(sclk) == e_sclk, "R1 R2 sclk", int'(sclk), e_sclk);
            chk(int'(mosi) == m_mosi, "R3 mosi", int'(mosi), m_mosi);
            chk(int'(fss_n) == m_fss, "R6 fss_n", int'(fss_n), m_fss);
            chk(int'(rx_valid) == m_rxv, "R5 rx_valid", int'(rx_valid), m_rxv);
            chk(int'(rx_data) == m_rxd, "R4 rx_data", int'(rx_data), m_rxd);
            chk(int'(tx_ready) == e_txr, "R7 tx_ready", int'(tx_ready), e_txr);
            chk(int'(busy) == e_busy, "R8 busy", int'(busy), e_busy);
        end
        // drive inputs for the next rising edge
        enable   = en_r;
        mode     = mode_r;
        width_m1 = wm1_r;
        prescale = pre_r;
        rate_fac = rate_r;
        tx_valid = (txq.size() > 0);
        tx_data  = (txq.size() > 0) ? txq[0] : 16'd0;
        case (rdy_mode)
            0:       rx_ready = 1'b1;
            1:       rx_ready = (cyc_cnt % 3) != 0;
            default: rx_ready = 1'b0;
        endcase
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        miso = lfsr[0];
        // step the model across the coming rising edge
        if (model_on && !rst) begin
            bit ld;
            ld = enable && tx_valid && (m_st != 1) && (m_rxv == 0);
            if (m_rxv != 0 && rx_ready) m_rxv = 0;
            if (!enable) begin
                m_st = 0; m_fss = 1; m_mosi = 0;
            end else if (m_st != 1) begin
                if (ld) begin
                    int hp;
                    m_pol  = int'(mode[1]);
                    m_pha  = int'(mode[0]);
                    m_w    = (int'(width_m1) < 3) ? 4 : int'(width_m1) + 1;
                    hp     = int'(prescale) / 2;
                    if (hp < 1) hp = 1;
                    m_h    = hp * (int'(rate_fac) + 1);
                    m_word = int'(tx_data) & ((1 << m_w) - 1);
                    m_st = 1; m_cyc = 0; m_e = 0; m_acc = 0;
                    m_sclk = m_pol; m_fss = 0;
                    m_mosi = (m_pha != 0) ? 0 : ((m_word >> (m_w - 1)) & 1);
                    void'(txq.pop_front());
                end else if (m_st == 2 && !tx_valid) begin
                    m_st = 0; m_fss = 1;
                end
            end else begin
                m_cyc++;
                if (m_cyc == m_h) begin
                    m_cyc = 0;
                    m_e++;
                    m_sclk = 1 - m_sclk;
                    if (m_e % 2 == 1) begin
                        if (m_pha == 0) m_acc = (m_acc << 1) | int'(miso);
                        else m_mosi = (m_word >> (m_w - 1 - (m_e - 1) / 2)) & 1;
                    end else begin
                        if (m_pha != 0) m_acc = (m_acc << 1) | int'(miso);
                        if (m_e == 2 * m_w) begin
                            m_st = 2; m_rxv = 1; m_rxd = m_acc; m_mosi = 0;
                        end else if (m_pha == 0) begin
                            m_mosi = (m_word >> (m_w - 1 - m_e / 2)) & 1;
                        end
                    end
                end
            end
        end
    end

    task automatic wait_cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wait_done();
        int t = 0;
        while (!(txq.size() == 0 && m_st == 0 && m_rxv == 0) && t < 20000) begin
            @(posedge clk);
            t++;
        end
        wait_cycles(3);
    endtask

    task automatic set_cfg(input logic [1:0] md, input logic [3:0] w, input logic [7:0] p, input logic [7:0] r);
        mode_r = md; wm1_r = w; pre_r = p; rate_r = r;
    endtask

    initial begin
        wait_cycles(3);
        rst = 1'b0;
        model_on = 1'b1;
        @(negedge clk);
        // R10: state right after reset
        chk(fss_n == 1'b1, "R10 fss_n", int'(fss_n), 1);
        chk(mosi == 1'b0, "R10 mosi", int'(mosi), 0);
        chk(rx_valid == 1'b0, "R10 rx_valid", int'(rx_valid), 0);
        chk(busy == 1'b0, "R10 busy", int'(busy), 0);
        wait_cycles(1);

        // mode 0, 8 bits, fastest clock, back-to-back words
        set_cfg(2'd0, 4'd7, 8'd2, 8'd0); en_r = 1'b1;
        txq.push_back(16'h00A5); txq.push_back(16'h013C); txq.push_back(16'hF0FF);
        wait_done();

        // mode 1, 16 bits, prescale 4, rate 1
        set_cfg(2'd1, 4'd15, 8'd4, 8'd1);
        txq.push_back(16'h8001); txq.push_back(16'h1234);
        wait_done();

        // mode 2, 4 bits, upper transmit bits set (R4)
        set_cfg(2'd2, 4'd3, 8'd6, 8'd2);
        txq.push_back(16'hFFF9); txq.push_back(16'h0006);
        wait_done();

        // mode 3, 12 bits, odd prescale (R1), intermittent rx_ready
        set_cfg(2'd3, 4'd11, 8'd5, 8'd3); rdy_mode = 1;
        txq.push_back(16'h0ABC); txq.push_back(16'h5F00); txq.push_back(16'h0777);
        wait_done();

        // width code below 3 and prescale 0 (R1, R4)
        rdy_mode = 0;
        set_cfg(2'd0, 4'd1, 8'd0, 8'd0);
        txq.push_back(16'h000D); txq.push_back(16'h0032);
        wait_done();

        // receive side stalled: word held, no new load, frame stays open
        set_cfg(2'd0, 4'd7, 8'd2, 8'd1); rdy_mode = 2;
        txq.push_back(16'h0011); txq.push_back(16'h0022); txq.push_back(16'h0033);
        wait_cycles(200);
        @(negedge clk);
        chk(rx_valid == 1'b1, "R5 held word", int'(rx_valid), 1);
        chk(tx_ready == 1'b0, "R7 no room", int'(tx_ready), 0);
        chk(fss_n == 1'b0, "R6 frame open in gap", int'(fss_n), 0);
        chk(busy == 1'b1, "R8 busy while stalled", int'(busy), 1);
        rdy_mode = 0;
        wait_done();

        // disable in the middle of a word
        set_cfg(2'd2, 4'd15, 8'd8, 8'd4);
        txq.push_back(16'hC3A5); txq.push_back(16'h5A3C);
        wait_cycles(100);
        en_r = 1'b0;
        wait_cycles(3);
        @(negedge clk);
        chk(fss_n == 1'b1, "R9 frame closed", int'(fss_n), 1);
        chk(sclk == 1'b1, "R9 clock idle", int'(sclk), 1);
        chk(tx_ready == 1'b0, "R9 no take", int'(tx_ready), 0);
        chk(mosi == 1'b0, "R9 mosi quiet", int'(mosi), 0);
        wait_cycles(50);
        @(negedge clk);
        chk(sclk == 1'b1 && fss_n == 1'b1, "R9 stays stopped", int'({sclk, fss_n}), 3);
        chk(txq.size() == 1, "R9 queue untouched", txq.size(), 1);
        en_r = 1'b1;
        wait_done();
        @(negedge clk);
        chk(busy == 1'b0, "R8 idle at end", int'(busy), 0);

        summary_and_end();
    end

endmodule